// File: doc/BRIEF.md
# Unified Add/Subtract Carry Unit

This is a purely combinational 64-bit arithmetic unit. It performs every add and subtract form with one shared adder, including the carrying and extended forms. All of them reduce to one equation: result = (A xor I) + B + C.

- I is a mask that is either all zeros or all ones, so it either passes A through or inverts it.
- B is picked from the register operand, the constant 0 or the constant -1.
- C is picked from 0, 1 or the stored carry flag.

Setting the three controls is enough to get plain add, subtract-from, the carrying and extended forms, and the add-minus-one forms. No other operator is needed.

The unit gives two carry outputs:
- the carry out of the most significant bit, for updating the carry flag in 64-bit mode;
- the carry out of bit 31, for word-mode operations.

Top module: `addsub_carry_unit`

## Requirements
- R1: `sum` equals ((`opa` xor I) + B + C) modulo 2^64, where I is all ones when `inv_a` is 1 and all zeros when it is 0.
- R2: With `inv_a` = 1, every bit of `opa` is complemented before the addition; with `inv_a` = 0, `opa` enters unchanged.
- R3: `b_sel` picks B as follows: 2'b00 selects `b_reg`, 2'b01 selects the constant 0, 2'b10 selects the constant all ones (-1), and 2'b11 selects the constant 0.
- R4: `c_sel` picks C as follows: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives `ca_in`, and the unused code 2'b11 gives 0.
- R5: `ca_out` is the carry out of bit 63 of the full addition, that is, bit 64 of the 65-bit sum.
- R6: `ca32_out` is the carry out of bit 31 of the same addition, that is, bit 32 of ((A xor I)[31:0] + B[31:0] + C).
- R7: Subtract-from (`inv_a` = 1, `b_sel` = 00, `c_sel` = 01) yields `b_reg` - `opa`, and `ca_out` = 1 exactly when `b_reg` >= `opa` as unsigned values.
- R8: Add-minus-one (`inv_a` = 0, `b_sel` = 10, `c_sel` = 10) yields `opa` + `ca_in` - 1, and `ca_out` = 1 exactly when `opa` is nonzero or `ca_in` is 1.
- R9: `ca_in` has no effect on any output unless `c_sel` = 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | Operand A |
| inv_a | input | 1 | Invert operand A before the addition |
| b_reg | input | 64 | Register value offered as the B source |
| b_sel | input | 2 | Selects the B source |
| c_sel | input | 2 | Selects the carry-in source |
| ca_in | input | 1 | Stored carry flag |
| sum | output | 64 | Result of the addition |
| ca_out | output | 1 | Carry out of bit 63 |
| ca32_out | output | 1 | Carry out of bit 31 |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath split at bit 32. This split puts both carry outputs within reach of directed operand patterns. Patterns such as all-ones plus one, 0xFFFF_FFFF in the low word and equal subtract operands drive a carry exactly across the word boundary and across the top bit. They also make each selector code observable in the sum, including the unused codes. Toggling the stored carry under every carry-in selection shows that it matters only under the stored-carry code.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    BSRC_REG  = 2'b00,
    BSRC_ZERO = 2'b01,
    BSRC_ONES = 2'b10,
    BSRC_RSVD = 2'b11
  } bsrc_e;

  typedef enum logic [1:0] {
    CSRC_ZERO  = 2'b00,
    CSRC_ONE   = 2'b01,
    CSRC_FLAG  = 2'b10,
    CSRC_RSVD  = 2'b11
  } csrc_e;

  // Carry out of an unsigned add of two n-bit values plus a carry-in bit.
  function automatic logic add_carry(input logic [63:0] x, input logic [63:0] y,
                                     input logic cin, input int n);
    logic c;
    c = cin;
    for (int k = 0; k < 64; k++) begin
      if (k < n) c = (x[k] & y[k]) | (x[k] & c) | (y[k] & c);
    end
    return c;
  endfunction
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_in,
  input  logic         inv,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   b_sel,
  output logic [W-1:0] a_x,
  output logic [W-1:0] b_x
);
  logic [W-1:0] inv_mask;

  always_comb begin
    inv_mask = {W{inv}};
    a_x = a_in ^ inv_mask;
    unique case (bsrc_e'(b_sel))
      BSRC_REG:  b_x = b_in;
      BSRC_ONES: b_x = '1;
      default:   b_x = '0;
    endcase
    // R2: difference between input and prepared A is either nothing or everything
    a_r2_inv_whole: assert (((a_x ^ a_in) == '0 && !inv) || ((a_x ^ a_in) == '1 && inv))
      else $error("a_r2_inv_whole");
    // R3: constants never leak the register operand
    a_r3_b_const: assert (!(b_sel == 2'b01 || b_sel == 2'b11) || b_x == '0)
      else $error("a_r3_b_const");
  end
endmodule

// File: rtl/addsub_carry_select.sv
module addsub_carry_select
  import addsub_pkg::*;
(
  input  logic [1:0] c_sel,
  input  logic       flag,
  output logic       cin
);
  always_comb begin
    cin = 1'b0;
    case (csrc_e'(c_sel))
      CSRC_ONE:  cin = 1'b1;
      CSRC_FLAG: cin = flag;
      default:   cin = 1'b0;
    endcase
    // R4/R9: the stored flag reaches the adder only under the flag code
    a_r9_flag_gated: assert (c_sel == 2'b10 || cin == c_sel[0] && c_sel != 2'b11 || cin == 1'b0)
      else $error("a_r9_flag_gated");
  end
endmodule

// File: rtl/addsub_segment.sv
module addsub_segment #(
  parameter int N = 32
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  always_comb begin
    {co, s} = {1'b0, x} + {1'b0, y} + {{N{1'b0}}, ci};
  end
endmodule

// File: rtl/addsub_carry_unit.sv
module addsub_carry_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int WORD  = 32
) (
  input  logic [63:0] opa,
  input  logic        inv_a,
  input  logic [63:0] b_reg,
  input  logic [1:0]  b_sel,
  input  logic [1:0]  c_sel,
  input  logic        ca_in,
  output logic [63:0] sum,
  output logic        ca_out,
  output logic        ca32_out
);
  localparam int HI = WIDTH - WORD;

  logic [WIDTH-1:0] a_x, b_x;
  logic             cin;
  logic             lo_co, hi_co;
  logic [WORD-1:0]  lo_s;
  logic [HI-1:0]    hi_s;

  addsub_operand_prep #(.W(WIDTH)) prep_i (
    .a_in(opa), .inv(inv_a), .b_in(b_reg), .b_sel(b_sel),
    .a_x(a_x), .b_x(b_x)
  );

  addsub_carry_select csel_i (.c_sel(c_sel), .flag(ca_in), .cin(cin));

  // low word segment produces the word-mode carry, high segment chains from it
  addsub_segment #(.N(WORD)) lo_i (
    .x(a_x[WORD-1:0]), .y(b_x[WORD-1:0]), .ci(cin), .s(lo_s), .co(lo_co)
  );

  generate
    if (HI > 0) begin : g_hi
      addsub_segment #(.N(HI)) hi_i (
        .x(a_x[WIDTH-1:WORD]), .y(b_x[WIDTH-1:WORD]), .ci(lo_co), .s(hi_s), .co(hi_co)
      );
    end else begin : g_nohi
      assign hi_s  = '0;
      assign hi_co = lo_co;
    end
  endgenerate

  always_comb begin
    sum      = {hi_s, lo_s};
    ca_out   = hi_co;
    ca32_out = lo_co;
  end

  // Checks relate the split adder to a bit-serial carry model over whole operands.
  always_comb begin
    // R5: top carry matches ripple model of full width
    a_r5_top_carry: assert (hi_co == add_carry(64'(a_x), 64'(b_x), cin, WIDTH))
      else $error("a_r5_top_carry");
    // R6: word carry matches ripple model of low word
    a_r6_word_carry: assert (lo_co == add_carry(64'(a_x), 64'(b_x), cin, WORD))
      else $error("a_r6_word_carry");
    // R1: concatenated segments equal a single wide add
    a_r1_one_sum: assert ({hi_co, hi_s, lo_s} == ({1'b0, a_x} + {1'b0, b_x} + (WIDTH+1)'(cin)))
      else $error("a_r1_one_sum");
  end
endmodule

// File: tb/addsub_carry_unit_tb.sv
module addsub_carry_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [63:0] opa, b_reg, sum;
  logic        inv_a, ca_in, ca_out, ca32_out;
  logic [1:0]  b_sel, c_sel;

  int n_chk = 0;
  int n_bad = 0;

  addsub_carry_unit dut_i (
    .opa(opa), .inv_a(inv_a), .b_reg(b_reg), .b_sel(b_sel), .c_sel(c_sel),
    .ca_in(ca_in), .sum(sum), .ca_out(ca_out), .ca32_out(ca32_out)
  );

  function automatic logic [65:0] model(input logic [63:0] a, input logic i,
      input logic [63:0] b, input logic [1:0] bs, input logic [1:0] cs, input logic f);
    logic [63:0] av, bv;
    logic cv;
    logic [64:0] full;
    logic [32:0] word;
    av = i ? ~a : a;
    bv = (bs == 2'b00) ? b : (bs == 2'b10) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
    cv = (cs == 2'b01) ? 1'b1 : (cs == 2'b10) ? f : 1'b0;
    full = {1'b0, av} + {1'b0, bv} + {64'd0, cv};
    word = {1'b0, av[31:0]} + {1'b0, bv[31:0]} + {32'd0, cv};
    return {word[32], full};
  endfunction

  task automatic drive(input logic [63:0] a, input logic i, input logic [63:0] b,
                       input logic [1:0] bs, input logic [1:0] cs, input logic f);
    @(negedge clk);
    opa = a; inv_a = i; b_reg = b; b_sel = bs; c_sel = cs; ca_in = f;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [63:0] es, input logic ec,
                            input logic ew);
    n_chk++;
    if (sum !== es || ca_out !== ec || ca32_out !== ew) begin
      n_bad++;
      $display("FAIL %s: got sum=%h ca=%b ca32=%b, expected sum=%h ca=%b ca32=%b",
               req, sum, ca_out, ca32_out, es, ec, ew);
    end
  endtask

  task automatic apply_model(input string req, input logic [63:0] a, input logic i,
      input logic [63:0] b, input logic [1:0] bs, input logic [1:0] cs, input logic f);
    logic [65:0] m;
    drive(a, i, b, bs, cs, f);
    m = model(a, i, b, bs, cs, f);
    expect_out(req, m[63:0], m[64], m[65]);
  endtask

  task automatic t_idle_zero;   // R1: all-zero inputs
    drive(64'd0, 1'b0, 64'd0, 2'b00, 2'b00, 1'b0);
    expect_out("R1 idle", 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_plain_add;   // R1, R5, R6
    drive(64'h0000_0001_0000_0002, 0, 64'h0000_0003_0000_0004, 2'b00, 2'b00, 0);
    expect_out("R1 add", 64'h0000_0004_0000_0006, 0, 0);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 2'b00, 2'b00, 0);
    expect_out("R5 wrap", 64'd0, 1, 1);
    drive(64'h0000_0000_FFFF_FFFF, 0, 64'd1, 2'b00, 2'b00, 0);
    expect_out("R6 word carry", 64'h0000_0001_0000_0000, 0, 1);
    drive(64'h8000_0000_0000_0000, 0, 64'h8000_0000_0000_0000, 2'b00, 2'b00, 0);
    expect_out("R5 top only", 64'd0, 1, 0);
  endtask

  task automatic t_invert;      // R2
    drive(64'h0123_4567_89AB_CDEF, 1, 64'd0, 2'b01, 2'b00, 0);
    expect_out("R2 invert", 64'hFEDC_BA98_7654_3210, 0, 0);
    drive(64'h0123_4567_89AB_CDEF, 0, 64'd0, 2'b01, 2'b00, 0);
    expect_out("R2 pass", 64'h0123_4567_89AB_CDEF, 0, 0);
  endtask

  task automatic t_bsel;        // R3
    drive(64'd5, 0, 64'd100, 2'b01, 2'b00, 0);
    expect_out("R3 zero", 64'd5, 0, 0);
    drive(64'd5, 0, 64'd100, 2'b10, 2'b00, 0);
    expect_out("R3 ones", 64'd4, 1, 1);
    drive(64'd5, 0, 64'd100, 2'b11, 2'b00, 0);
    expect_out("R3 code3", 64'd5, 0, 0);
    drive(64'd5, 0, 64'd100, 2'b00, 2'b00, 0);
    expect_out("R3 reg", 64'd105, 0, 0);
  endtask

  task automatic t_csel;        // R4
    drive(64'd7, 0, 64'd0, 2'b01, 2'b00, 1);
    expect_out("R4 c0", 64'd7, 0, 0);
    drive(64'd7, 0, 64'd0, 2'b01, 2'b01, 0);
    expect_out("R4 c1", 64'd8, 0, 0);
    drive(64'd7, 0, 64'd0, 2'b01, 2'b10, 1);
    expect_out("R4 flag", 64'd8, 0, 0);
    drive(64'd7, 0, 64'd0, 2'b01, 2'b11, 1);
    expect_out("R4 code3", 64'd7, 0, 0);
  endtask

  task automatic t_subf;        // R7
    drive(64'd10, 1, 64'd25, 2'b00, 2'b01, 0);
    expect_out("R7 b>a", 64'd15, 1, 1);
    drive(64'd25, 1, 64'd10, 2'b00, 2'b01, 0);
    expect_out("R7 b<a", 64'hFFFF_FFFF_FFFF_FFF1, 0, 0);
    drive(64'h1234_5678_0000_0000, 1, 64'h1234_5678_0000_0000, 2'b00, 2'b01, 0);
    expect_out("R7 equal", 64'd0, 1, 1);
  endtask

  task automatic t_addme;       // R8
    drive(64'd0, 0, 64'd0, 2'b10, 2'b10, 0);
    expect_out("R8 zero nc", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    drive(64'd0, 0, 64'd0, 2'b10, 2'b10, 1);
    expect_out("R8 zero c", 64'd0, 1, 1);
    drive(64'h0000_0001_0000_0000, 0, 64'd0, 2'b10, 2'b10, 0);
    expect_out("R8 nonzero", 64'h0000_0000_FFFF_FFFF, 1, 0);
  endtask

  task automatic t_flag_ignored; // R9
    for (int cs = 0; cs < 4; cs++) begin
      if (cs != 2) begin
        apply_model("R9 flag0", 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd0, 2'b00, cs[1:0], 0);
        apply_model("R9 flag1", 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd0, 2'b00, cs[1:0], 1);
      end
    end
  endtask

  task automatic t_sweep;       // R1 general patterns
    logic [63:0] a, b;
    a = 64'h9E37_79B9_7F4A_7C15;
    b = 64'hD1B5_4A32_D192_ED03;
    for (int k = 0; k < 48; k++) begin
      apply_model("R1 sweep", a, k[0], b, k[2:1], k[4:3], k[5]);
      a = {a[62:0], a[63] ^ a[61]} + 64'h3C6E_F372;
      b = (b ^ (b << 13)) ^ (b >> 7);
    end
  endtask

  initial begin
    opa = '0; inv_a = 0; b_reg = '0; b_sel = 0; c_sel = 0; ca_in = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle_zero();
    t_plain_add();
    t_invert();
    t_bsel();
    t_csel();
    t_subf();
    t_addme();
    t_flag_ignored();
    t_sweep();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule